// File: doc/BRIEF.md
# Compact Eight-Bit Register Machine Core

This block is a small multi-cycle processor core. It holds four 8-bit general registers, an 8-bit program counter and one 256-byte memory that stores both code and data. Each instruction is one byte. The immediate forms add a second byte. A single-port RAM with a one-cycle read delay serves every access. A four-state sequencer steps each instruction through fetch and decode. When the instruction needs it, the sequencer adds an immediate read and a final memory read whose data goes back into a register.

The core has two modes of use. While reset is held, a host loads a program and its data through a simple byte write port. Once reset is released, the core runs from address zero until it reaches an instruction with the top bit set. It then stays on that address. Debug outputs show the PC, all four registers and a halted flag, so a surrounding test environment can read the final machine state.

Top module: `tcpu_core`

## Requirements
- R1: While `rst` is high, the PC, all registers and the halted flag read zero, and each cycle with `host_we` high writes `host_wdata` into memory at `host_addr`. After `rst` falls, execution starts at address 0.
- R2: An instruction byte is decoded by field: bit 7 is the stop flag, bits 6:4 select the operation, bits 3:2 name the destination register A, and bits 1:0 name the source register B or select a variant.
- R3: A byte with bit 7 set changes no register, no memory location and not the PC, and it raises `dbg_halted`. The core keeps fetching that same address.
- R4: Operations 0, 1 and 2 set A to B, to A plus B, or to A AND B, and advance the PC by 1.
- R5: Operation 3 loads A from memory at the address held in B. Operation 4 stores A to memory at the address held in B. Both advance the PC by 1.
- R6: Operation 5 rewrites A according to field B: 0 gives the bitwise inverse, 1 the two's-complement negation, 2 the value 1 if A was zero and 0 otherwise, and 3 the address of the instruction itself. The PC advances by 1.
- R7: Operation 6 reads the byte that follows the instruction as an immediate. Field B values 0, 1 and 2 set A to the immediate, to A plus the immediate, or to A AND the immediate. The PC advances by 2.
- R8: Operation 6 with field B equal to 3 loads A from memory at the address given by the immediate, and the PC advances by 2.
- R9: Operation 7 reads A as a signed byte. If A is zero or negative, the PC becomes the value of B. Otherwise the PC advances by 1.
- R10: All register arithmetic and PC updates wrap modulo 256.
- R11: A plain instruction takes 2 cycles. An immediate form or a register-addressed load takes 3 cycles, and the immediate-addressed load takes 4. The PC therefore never changes on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables host loading |
| host_we | input | 1 | Host memory write strobe, honoured only during reset |
| host_addr | input | 8 | Host write address |
| host_wdata | input | 8 | Host write data |
| dbg_pc | output | 8 | Current program counter |
| dbg_regs | output | 32 | Registers packed, register 0 in bits 7:0 up to register 3 in bits 31:24 |
| dbg_halted | output | 1 | High after a stop-flagged byte has been decoded |

## Verification
The assertions assume that memory changes only through the host port during reset and through the core's own stores afterwards. The halt and jump properties rely on this, since they take the byte just fetched as the instruction being executed. The bench keeps to this assumption: it loads every memory location, all 256 of them, while reset is held, and it drives `host_we` low before releasing reset. Each program ends in a stop byte, so every run settles in the halted state. The final state is then read out and compared.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

    localparam int unsigned DW      = 8;
    localparam int unsigned AW      = 8;
    localparam int unsigned NREG    = 4;
    localparam int unsigned RSEL    = $clog2(NREG);
    localparam int unsigned MEM_DEP = 1 << AW;

    typedef enum logic [2:0] {
        OP_MOV = 3'd0,
        OP_ADD = 3'd1,
        OP_AND = 3'd2,
        OP_LD  = 3'd3,
        OP_ST  = 3'd4,
        OP_UNI = 3'd5,
        OP_IMM = 3'd6,
        OP_BLE = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_IMM    = 2'd2,
        ST_WB     = 2'd3
    } st_e;

    typedef struct packed {
        logic             stop;
        op_e              op;
        logic [RSEL-1:0]  ra;
        logic [RSEL-1:0]  rb;
    } insn_t;

    localparam logic [1:0] SUB_INDIRECT = 2'd3;

    function automatic logic is_nonpos(input logic [DW-1:0] v);
        return v[DW-1] | (v == '0);
    endfunction

endpackage

// File: rtl/tcpu_ram.sv
module tcpu_ram #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile #(
    parameter int unsigned NREG = 4,
    parameter int unsigned DW   = 8,
    localparam int unsigned RSEL = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [RSEL-1:0]    wsel,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] rd_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [DW-1:0] r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                r_q <= '0;
            end else if (we && (wsel == RSEL'(g))) begin
                r_q <= wdata;
            end
        end
        assign rd_flat[g*DW +: DW] = r_q;
    end

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu #(
    parameter int unsigned DW = 8
) (
    input  logic [1:0]    kind,
    input  logic [1:0]    usel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [DW-1:0] pc,
    output logic [DW-1:0] comb_res,
    output logic [DW-1:0] uni_res
);
    always_comb begin
        unique case (kind)
            2'd0:    comb_res = b;
            2'd1:    comb_res = a + b;
            2'd2:    comb_res = a & b;
            default: comb_res = b;
        endcase
    end

    always_comb begin
        unique case (usel)
            2'd0:    uni_res = ~a;
            2'd1:    uni_res = DW'(0) - a;
            2'd2:    uni_res = {{(DW-1){1'b0}}, (a == '0)};
            default: uni_res = pc;
        endcase
    end

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
    import tcpu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        host_we,
    input  logic [7:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  dbg_pc,
    output logic [31:0] dbg_regs,
    output logic        dbg_halted
);
    st_e            st_q, st_d;
    logic [AW-1:0]  pc_q, pc_d;
    insn_t          ir_q, ir_d;
    logic           halt_q, halt_d;

    logic [AW-1:0]  core_addr, ram_addr;
    logic           core_we, ram_we;
    logic [DW-1:0]  core_wd, ram_wd, ram_rdata;

    logic           rf_we;
    logic [DW-1:0]  rf_wd;
    logic [NREG*DW-1:0] rf_flat;
    logic [DW-1:0]  regs [NREG];

    insn_t          cur;
    logic [DW-1:0]  ra_val, rb_val;
    logic [1:0]     alu_kind;
    logic [DW-1:0]  alu_b, comb_res, uni_res;

    // Host owns the memory port for the whole reset period.
    assign ram_we   = rst ? host_we    : core_we;
    assign ram_addr = rst ? host_addr  : core_addr;
    assign ram_wd   = rst ? host_wdata : core_wd;

    tcpu_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (ram_rdata)
    );

    tcpu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (rf_we),
        .wsel    (cur.ra),
        .wdata   (rf_wd),
        .rd_flat (rf_flat)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_view
        assign regs[g] = rf_flat[g*DW +: DW];
    end

    // In decode the fresh read data is the instruction; later states use the latched copy.
    assign cur    = (st_q == ST_DECODE) ? insn_t'(ram_rdata) : ir_q;
    assign ra_val = regs[cur.ra];
    assign rb_val = regs[cur.rb];

    assign alu_kind = (st_q == ST_IMM) ? cur.rb    : 2'(cur.op);
    assign alu_b    = (st_q == ST_IMM) ? ram_rdata : rb_val;

    tcpu_alu #(.DW(DW)) u_alu (
        .kind     (alu_kind),
        .usel     (cur.rb),
        .a        (ra_val),
        .b        (alu_b),
        .pc       (pc_q),
        .comb_res (comb_res),
        .uni_res  (uni_res)
    );

    always_comb begin
        st_d      = st_q;
        pc_d      = pc_q;
        ir_d      = ir_q;
        halt_d    = halt_q;
        core_addr = pc_q;
        core_we   = 1'b0;
        core_wd   = ra_val;
        rf_we     = 1'b0;
        rf_wd     = comb_res;

        unique case (st_q)
            ST_FETCH: begin
                core_addr = pc_q;
                st_d      = ST_DECODE;
            end

            ST_DECODE: begin
                ir_d   = cur;
                halt_d = cur.stop;
                st_d   = ST_FETCH;
                if (!cur.stop) begin
                    unique case (cur.op)
                        OP_MOV, OP_ADD, OP_AND: begin
                            rf_we = 1'b1;
                            rf_wd = comb_res;
                            pc_d  = pc_q + AW'(1);
                        end
                        OP_LD: begin
                            core_addr = rb_val;
                            st_d      = ST_WB;
                        end
                        OP_ST: begin
                            core_addr = rb_val;
                            core_we   = 1'b1;
                            pc_d      = pc_q + AW'(1);
                        end
                        OP_UNI: begin
                            rf_we = 1'b1;
                            rf_wd = uni_res;
                            pc_d  = pc_q + AW'(1);
                        end
                        OP_IMM: begin
                            core_addr = pc_q + AW'(1);
                            st_d      = ST_IMM;
                        end
                        default: begin
                            pc_d = is_nonpos(ra_val) ? rb_val : pc_q + AW'(1);
                        end
                    endcase
                end
            end

            ST_IMM: begin
                if (cur.rb == SUB_INDIRECT) begin
                    core_addr = ram_rdata;
                    st_d      = ST_WB;
                end else begin
                    rf_we = 1'b1;
                    rf_wd = comb_res;
                    pc_d  = pc_q + AW'(2);
                    st_d  = ST_FETCH;
                end
            end

            default: begin
                rf_we = 1'b1;
                rf_wd = ram_rdata;
                pc_d  = (cur.op == OP_IMM) ? pc_q + AW'(2) : pc_q + AW'(1);
                st_d  = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_FETCH;
            pc_q   <= '0;
            ir_q   <= '0;
            halt_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pc_q   <= pc_d;
            ir_q   <= ir_d;
            halt_q <= halt_d;
        end
    end

    assign dbg_pc     = pc_q;
    assign dbg_regs   = rf_flat;
    assign dbg_halted = halt_q;

endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  dbg_pc,
    input logic [31:0] dbg_regs,
    input logic        dbg_halted,
    input logic [1:0]  st,
    input logic [7:0]  mem_q
);
    logic [7:0] ra, rb;
    logic       in_dec, dec_ble, dec_imm;

    always_comb begin
        ra      = dbg_regs[{mem_q[3:2], 3'b000} +: 8];
        rb      = dbg_regs[{mem_q[1:0], 3'b000} +: 8];
        in_dec  = (st == 2'd1);
        dec_ble = in_dec && (mem_q[7:4] == 4'h7);
        dec_imm = in_dec && (mem_q[7:4] == 4'h6);
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (dbg_pc == 8'h00 && dbg_regs == 32'h0 && !dbg_halted));

    a_r3_halt_holds_pc: assert property (@(posedge clk) disable iff (rst)
        dbg_halted |=> $stable(dbg_pc));

    a_r3_halt_holds_regs: assert property (@(posedge clk) disable iff (rst)
        dbg_halted |=> $stable(dbg_regs));

    a_r7_imm_enters_imm_state: assert property (@(posedge clk) disable iff (rst)
        dec_imm |=> (st == 2'd2));

    a_r9_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (dec_ble && (ra[7] || ra == 8'h00)) |=> (dbg_pc == $past(rb)));

    a_r9_jump_not_taken: assert property (@(posedge clk) disable iff (rst)
        (dec_ble && !ra[7] && ra != 8'h00) |=> (dbg_pc == $past(dbg_pc) + 8'd1));

    a_r11_pc_spacing: assert property (@(posedge clk) disable iff (rst)
        (dbg_pc != $past(dbg_pc)) |=> $stable(dbg_pc));

endmodule

bind tcpu_core tcpu_core_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .dbg_pc     (dbg_pc),
    .dbg_regs   (dbg_regs),
    .dbg_halted (dbg_halted),
    .st         (st_q),
    .mem_q      (ram_rdata)
);

// File: tb/tb_tcpu_core.sv
module tb_tcpu_core;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_LIMIT  = 3000;

    localparam int K_PC   = 0;
    localparam int K_REG  = 1;
    localparam int K_HALT = 2;
    localparam int K_CYC  = 3;

    typedef struct {
        int         kind;
        int         idx;
        int         val;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  dbg_pc;
    logic [31:0] dbg_regs;
    logic        dbg_halted;

    logic [7:0]  img [256];
    item_t       sb_q [$];
    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    tcpu_core dut (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .dbg_pc     (dbg_pc),
        .dbg_regs   (dbg_regs),
        .dbg_halted (dbg_halted)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver side of the scoreboard.
    task automatic push(input int kind, input int idx, input int val, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.val = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic expect_state(input int pc, input int r0, input int r1,
                                input int r2, input int r3, input string tag);
        push(K_PC, 0, pc, tag);
        push(K_REG, 0, r0, tag);
        push(K_REG, 1, r1, tag);
        push(K_REG, 2, r2, tag);
        push(K_REG, 3, r3, tag);
        push(K_HALT, 0, 1, "R3");
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor side: compares queued expectations with the observed outputs.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                int    act;
                it = sb_q.pop_front();
                case (it.kind)
                    K_PC:    act = int'(dbg_pc);
                    K_REG:   act = int'(dbg_regs[it.idx*8 +: 8]);
                    K_HALT:  act = int'(dbg_halted);
                    default: act = cyc;
                endcase
                n_checks++;
                if (act != it.val) begin
                    n_errors++;
                    $display("FAIL %s kind=%0d idx=%0d actual=%0h expected=%0h",
                             it.tag, it.kind, it.idx, act, it.val);
                end
            end
        end
    end

    task automatic clear_img();
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
    endtask

    task automatic run_prog();
        rst = 1'b1;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            host_we    = 1'b1;
            host_addr  = 8'(i);
            host_wdata = img[i];
        end
        @(negedge clk);
        host_we = 1'b0;
        rst     = 1'b0;
        cyc     = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!dbg_halted && cyc < RUN_LIMIT);
        if (!dbg_halted) begin
            n_checks++;
            n_errors++;
            $display("FAIL R3 run did not halt actual=0 expected=1");
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_state(0, 0, 0, 0, 0, "R1");
        void'(sb_q.pop_back());
        push(K_HALT, 0, 0, "R1");
        drain();

        // R2 R4 R5 R7: moves, store and load back, halt byte at 7
        clear_img();
        img[0] = 8'h68; img[1] = 8'h23; img[2] = 8'h06; img[3] = 8'h60;
        img[4] = 8'h20; img[5] = 8'h44; img[6] = 8'h3C; img[7] = 8'h80;
        run_prog();
        expect_state(8'h07, 8'h20, 8'h23, 8'h23, 8'h23, "R5");
        push(K_CYC, 0, 15, "R11");
        drain();

        // R4 R5: sum of two data bytes stored, then read back
        clear_img();
        img[0] = 8'h68; img[1] = 8'h10; img[2] = 8'h32; img[3] = 8'h68;
        img[4] = 8'h11; img[5] = 8'h36; img[6] = 8'h14; img[7] = 8'h68;
        img[8] = 8'h12; img[9] = 8'h46; img[10] = 8'h3E; img[11] = 8'h80;
        img[16] = 8'h23; img[17] = 8'hA1;
        run_prog();
        expect_state(8'h0B, 8'h23, 8'hC4, 8'h12, 8'hC4, "R4");
        drain();

        // R6: inverse, negate, logical not of zero, own address
        clear_img();
        img[0] = 8'h64; img[1] = 8'h89; img[2] = 8'h54; img[3] = 8'h68;
        img[4] = 8'h89; img[5] = 8'h59; img[6] = 8'h5E; img[7] = 8'h53;
        img[8] = 8'h80;
        run_prog();
        expect_state(8'h08, 8'h07, 8'h76, 8'h77, 8'h01, "R6");
        drain();

        // R7 R10 R6 R4: immediate forms, wrapping add, not of nonzero, reg AND
        clear_img();
        img[0]  = 8'h64; img[1]  = 8'h14; img[2]  = 8'h65; img[3]  = 8'h20;
        img[4]  = 8'h68; img[5]  = 8'hF0; img[6]  = 8'h69; img[7]  = 8'h30;
        img[8]  = 8'h6C; img[9]  = 8'hF5; img[10] = 8'h6E; img[11] = 8'h3C;
        img[12] = 8'h5A; img[13] = 8'h11; img[14] = 8'h61; img[15] = 8'h3C;
        img[16] = 8'h23; img[17] = 8'h80;
        run_prog();
        expect_state(8'h11, 8'h30, 8'h34, 8'h00, 8'h34, "R10");
        drain();

        // R8: loads through the address carried in the immediate
        clear_img();
        img[0] = 8'h67; img[1] = 8'h08; img[2] = 8'h6B; img[3] = 8'h09;
        img[4] = 8'h80; img[8] = 8'h5A; img[9] = 8'hC3;
        run_prog();
        expect_state(8'h04, 8'h00, 8'h5A, 8'hC3, 8'h00, "R8");
        push(K_CYC, 0, 10, "R11");
        drain();

        // R9: signed compare against zero at the boundaries
        for (int k = 0; k < 5; k++) begin
            logic [7:0] v;
            int         tgt;
            case (k)
                0: v = 8'hFF;
                1: v = 8'h80;
                2: v = 8'h00;
                3: v = 8'h01;
                default: v = 8'h7F;
            endcase
            tgt = (v[7] || v == 8'h00) ? 8'h14 : 8'h05;
            clear_img();
            img[0] = 8'h64; img[1] = 8'h14; img[2] = 8'h68; img[3] = v;
            img[4] = 8'h79; img[5] = 8'h80; img[20] = 8'h80;
            run_prog();
            expect_state(tgt, 8'h00, 8'h14, int'(v), 8'h00, "R9");
            drain();
        end

        // R3: halt persists with nothing changing
        repeat (20) @(negedge clk);
        expect_state(8'h05, 8'h00, 8'h14, 8'h7F, 8'h00, "R3");
        drain();

        finish_run();
    end

endmodule